// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

The controller gathers one-cycle interrupt pulses from up to sixteen sources into a request register, so that no pulse is lost while the CPU is busy. Each source carries an enable bit and a 2-bit priority field. Enabled, pending sources compete first on level and then on a fixed index order. A parameter marks a subset of sources, such as traps and failure detectors, that always compete at the top level.

The CPU sees a registered `irq_valid` and `irq_id` pair. Asserting `ack` while `irq_valid` is high retires the presented source. Software changes state through a single write port. The request operation ANDs the request register with the written mask in one cycle. This acts as an atomic clear, and any pulse arriving in the same cycle still survives.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[i]` sets `pending[i]` at the next clock edge, whether or not source i is enabled or has a level.
- R2: The priority field of source i is `reg_wdata[2i+1:2i]` of a write with `reg_op`=2'b10. The encoding is 00 = no level (never presented), 01 = level 1, 10 = level 2 and 11 = level 3. A higher level always wins over a lower one.
- R3: Among eligible sources on the same level, the lowest index wins.
- R4: Sources whose bit is set in `FORCED_SRC` (default sources 0 to 2) compete at level 3 whatever their priority field holds, 00 included.
- R5: A write with `reg_op`=2'b01 loads the enable bits from `reg_wdata[NSRC-1:0]`. A disabled source keeps its pending bit but is never presented.
- R6: `ack` high while `irq_valid` is high clears only `pending[irq_id]` at that edge. `ack` while `irq_valid` is low changes nothing.
- R7: A write with `reg_op`=2'b00 performs pending <= pending AND `reg_wdata[NSRC-1:0]` in one cycle. A 0 clears the bit and a 1 leaves it unchanged. `reg_op`=2'b11 has no effect.
- R8: A pulse in the same cycle as an acknowledge or software clear of that bit leaves the bit set.
- R9: `irq_valid`/`irq_id` are registered and show the winner over the register state after each edge. While `irq_valid` is high and `ack` is low, `irq_id` holds as long as that source stays pending, enabled and levelled, even if a higher-priority source arrives.
- R10: A synchronous reset clears the pending, enable and priority registers and drops `irq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pulse | input | NSRC | One-cycle request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 2 | 00 request AND-mask, 01 enables, 10 priority fields, 11 none |
| reg_wdata | input | 2*NSRC | Write data |
| ack | input | 1 | CPU acknowledge of the presented source |
| irq_valid | output | 1 | An eligible request is presented |
| irq_id | output | IDW | Index of the presented source |
| pending | output | NSRC | Request register contents |

## Verification
Every cycle, the assertions check four properties. A pulse always appears in `pending`. An acknowledged source is gone afterwards unless it pulsed again. A software mask leaves no bit set that was neither kept nor pulsed. A presented source is always pending and stays presented without an acknowledge or write. The level ordering, the forced-level override, the index tie-break and the effect of enables can only be shown by scenarios that set up competing sources. These scenarios are built as directed cases and random traffic, which the bench compares against its own arbitration model.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 16,
  parameter int IDW = $clog2(NSRC),
  parameter logic [NSRC-1:0] FORCED_SRC = NSRC'(7),
  localparam int DW = 2 * NSRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            reg_we,
  input  logic [1:0]      reg_op,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            ack,
  output logic            irq_valid,
  output logic [IDW-1:0]  irq_id,
  output logic [NSRC-1:0] pending
);
  localparam logic [1:0] OP_REQ = 2'b00, OP_EN = 2'b01, OP_PRIO = 2'b10;

  logic [NSRC-1:0] req_q, en_q, req_n, en_n, ack_clr, sw_keep;
  logic [DW-1:0]   prio_q, prio_n;
  logic [1:0]      best, lvl;
  logic [IDW-1:0]  win_id;
  logic            win_found, hold;

  assign ack_clr = (irq_valid && ack) ? (NSRC'(1) << irq_id) : '0;
  assign sw_keep = (reg_we && reg_op == OP_REQ) ? reg_wdata[NSRC-1:0] : '1;
  assign req_n   = (req_q & ~ack_clr & sw_keep) | src_pulse;
  assign en_n    = (reg_we && reg_op == OP_EN) ? reg_wdata[NSRC-1:0] : en_q;
  assign prio_n  = (reg_we && reg_op == OP_PRIO) ? reg_wdata : prio_q;
  assign pending = req_q;

  always_comb begin
    best = 2'd0;
    win_id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      lvl = FORCED_SRC[i] ? 2'd3 : prio_n[2*i +: 2];
      if (req_n[i] && en_n[i] && lvl != 2'd0 && lvl >= best) begin
        best = lvl;
        win_id = IDW'(i);
      end
    end
    win_found = (best != 2'd0);
  end

  assign hold = irq_valid && !ack && req_n[irq_id] && en_n[irq_id] &&
                (FORCED_SRC[irq_id] || prio_n[{irq_id, 1'b0} +: 2] != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
      en_q <= '0;
      prio_q <= '0;
      irq_valid <= 1'b0;
      irq_id <= '0;
    end else begin
      req_q <= req_n;
      en_q <= en_n;
      prio_q <= prio_n;
      if (!hold) begin
        irq_valid <= win_found;
        irq_id <= win_id;
      end
    end
  end

  assert_pulse_latched_R1: assert property (@(posedge clk) disable iff (rst)
    src_pulse != '0 |=> (($past(src_pulse) & ~pending) == '0));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ack && !src_pulse[irq_id]) |=> !pending[$past(irq_id)]);

  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_op == OP_REQ && !ack) |=>
      ((pending & ~($past(req_q) & $past(reg_wdata[NSRC-1:0])) & ~$past(src_pulse)) == '0));

  assert_presented_pending_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> pending[irq_id]);

  assert_id_held_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !ack && !reg_we) |=> (irq_valid && $stable(irq_id)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam logic [NSRC-1:0] FORCED = 16'h0007;

  logic clk = 0, rst = 1, reg_we = 0, ack = 0;
  logic [NSRC-1:0] src_pulse = '0;
  logic [1:0] reg_op = '0;
  logic [2*NSRC-1:0] reg_wdata = '0;
  logic irq_valid;
  logic [3:0] irq_id;
  logic [NSRC-1:0] pending;
  int checks = 0, fails = 0;

  logic [NSRC-1:0] mreq = '0, men = '0;
  logic [2*NSRC-1:0] mprio = '0;
  logic mv = 0;
  logic [3:0] mid = '0;

  prio_irq_ctrl dut_i (.clk(clk), .rst(rst), .src_pulse(src_pulse), .reg_we(reg_we),
    .reg_op(reg_op), .reg_wdata(reg_wdata), .ack(ack), .irq_valid(irq_valid),
    .irq_id(irq_id), .pending(pending));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] lvl_of(input logic [2*NSRC-1:0] p, input int i);
    return FORCED[i] ? 2'd3 : p[2*i +: 2];
  endfunction

  function automatic logic [4:0] arb(input logic [NSRC-1:0] r, input logic [NSRC-1:0] e,
                                     input logic [2*NSRC-1:0] p);
    logic [1:0] b = 0;
    logic [3:0] w = 0;
    for (int i = 0; i < NSRC; i++)
      if (r[i] && e[i] && lvl_of(p, i) > b) begin b = lvl_of(p, i); w = 4'(i); end
    return {b != 0, w};
  endfunction

  always @(posedge clk) begin
    logic [NSRC-1:0] nr, ne;
    logic [2*NSRC-1:0] np;
    logic [4:0] a;
    if (rst) begin
      mreq = '0; men = '0; mprio = '0; mv = 0; mid = '0;
    end else begin
      nr = mreq;
      if (mv && ack) nr[mid] = 1'b0;
      if (reg_we && reg_op == 2'b00) nr = nr & reg_wdata[NSRC-1:0];
      nr = nr | src_pulse;
      ne = (reg_we && reg_op == 2'b01) ? reg_wdata[NSRC-1:0] : men;
      np = (reg_we && reg_op == 2'b10) ? reg_wdata : mprio;
      if (!(mv && !ack && nr[mid] && ne[mid] && lvl_of(np, int'(mid)) != 0)) begin
        a = arb(nr, ne, np);
        mv = a[4]; mid = a[3:0];
      end
      mreq = nr; men = ne; mprio = np;
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk(input string tag);
    cmp(tag, "pending", int'(pending), int'(mreq));
    cmp(tag, "irq_valid", int'(irq_valid), int'(mv));
    if (mv) cmp(tag, "irq_id", int'(irq_id), int'(mid));
  endtask

  task automatic cyc(input logic [NSRC-1:0] p, input logic we, input logic [1:0] op,
                     input logic [2*NSRC-1:0] wd, input logic a, input string tag);
    src_pulse = p; reg_we = we; reg_op = op; reg_wdata = wd; ack = a;
    @(negedge clk);
    src_pulse = '0; reg_we = 0; ack = 0;
    chk(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [2*NSRC-1:0] pr;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10");
    cmp("R10", "reset pending", int'(pending), 0);
    cyc(16'h0020, 0, 0, 0, 0, "R1");
    cmp("R1", "latched while disabled", int'(pending), 'h20);
    cmp("R5", "disabled not presented", int'(irq_valid), 0);
    cyc(0, 1, 2'b01, 32'hFFFF, 0, "R2");
    cmp("R2", "level 00 never presented", int'(irq_valid), 0);
    pr = '0; pr[11:10] = 2'b01; pr[19:18] = 2'b11; pr[21:20] = 2'b11;
    cyc(16'h0600, 1, 2'b10, pr, 0, "R3");
    cmp("R3", "lower index wins tie", int'(irq_id), 9);
    cyc(16'h0002, 0, 0, 0, 0, "R9");
    cmp("R9", "id held on new arrival", int'(irq_id), 9);
    cyc(0, 0, 0, 0, 1, "R6");
    cmp("R6", "only winner cleared", int'(pending), 'h0422);
    cmp("R4", "forced source wins", int'(irq_id), 1);
    cyc(16'h0002, 0, 0, 0, 1, "R8");
    cmp("R8", "pulse beats ack", int'(pending), 'h0422);
    cyc(16'h0020, 1, 2'b00, 32'h0000FFDD, 0, "R7");
    cmp("R7", "mask clear with pulse", int'(pending), 'h0420);
    cyc(0, 1, 2'b11, 32'h0, 0, "R7");
    cmp("R7", "op 11 no effect", int'(pending), 'h0420);
    cyc(0, 1, 2'b01, 32'hFBFF, 0, "R5");
    cmp("R5", "disable leaves lower level", int'(irq_id), 5);
    cyc(0, 0, 0, 0, 1, "R6");
    cmp("R6", "ack clears level-1 source", int'(pending), 'h0400);
    cmp("R6", "nothing eligible left", int'(irq_valid), 0);
    cyc(0, 0, 0, 0, 1, "R6");
    cmp("R6", "ack without valid ignored", int'(pending), 'h0400);
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op = 2'($urandom);
      logic [2*NSRC-1:0] wd = $urandom;
      logic we = ($urandom % 6) == 0;
      if (op == 2'b00) wd = ~(32'h1 << ($urandom % 16));
      cyc(16'($urandom & $urandom & $urandom), we, op, wd, ($urandom % 3) == 0, "R9");
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule